// File: doc/BRIEF.md
# Descriptor Completion Interrupt Evaluator

This block decides, once per finished DMA command, whether the channel should notify the interrupt controller. Each descriptor carries a two-bit interrupt policy. The policy can suppress the request, force it, or make it depend on a masked comparison between the live channel status word and a programmable select register. The upper half of the select register is the bit mask and the lower half is the compare value. Stop-class opcodes never notify, whatever their policy says.

The channel engine pulses an evaluation strobe in two cases: when a command completes, and when software clears the run bit. On that strobe it presents the descriptor's third byte, the opcode and the current status. The block answers with a registered single-cycle request in the next cycle. Software writes the select register through a simple write port, and its current contents can be read back.

Top module: `cmpl_irq_eval`

## Requirements
- R1: `irq_pulse` is high in the cycle directly after an evaluation strobe (`cmd_done` or `run_clear`) whose policy allows a request. It is low in every cycle not preceded by such a strobe.
- R2: The policy is taken from bits 5:4 of `desc_byte2`. Bits 7:6 and 3:0 of that byte have no effect on `irq_pulse`.
- R3: Policy 2'b00 never produces a request.
- R4: Policy 2'b11 always produces a request, for every opcode below the stop code.
- R5: The condition is true when (`chan_status` AND mask) equals (compare value AND mask), where the mask is `sel_value[31:16]` and the compare value is `sel_value[15:0]`. Policy 2'b01 requests when the condition is true.
- R6: Policy 2'b10 requests when the condition is false.
- R7: An opcode of 7 (the stop code) or any larger 4-bit value never produces a request, under every policy.
- R8: `run_clear` evaluates exactly like `cmd_done`. Both strobes together in one cycle give a single one-cycle request.
- R9: The select register resets to zero, so after reset policy 2'b01 always requests and policy 2'b10 never does. A write appears on `sel_value` in the next cycle. An evaluation in the same cycle as a write uses the value held before that write.
- R10: While reset is asserted, `irq_pulse` and `sel_value` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr_en | input | 1 | Write strobe for the select register |
| sel_wr_data | input | 32 | Select register write data (mask in upper half, compare value in lower half) |
| sel_value | output | 32 | Current select register contents |
| cmd_done | input | 1 | Command-completion evaluation strobe |
| run_clear | input | 1 | Run-bit-cleared evaluation strobe |
| desc_byte2 | input | 8 | Third byte of the completed descriptor; policy in bits 5:4 |
| opcode | input | 4 | Opcode of the completed command |
| chan_status | input | 16 | Current channel status word |
| irq_pulse | output | 1 | Registered one-cycle interrupt request |

## Verification
The hardest case to reach is an evaluation strobe that lands in the same cycle as a select-register write. In that cycle the old and new select values give opposite verdicts, so a design that looks through to the incoming data would raise the wrong request. The stimulus writes a mask and compare value that flip the conditional outcome while a strobe is present. It also runs a long random phase in which writes, both strobes, all opcodes and all policies overlap freely. The reference model checks every cycle against the register value it kept itself.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  // Interrupt policy carried by a completed descriptor
  typedef enum logic [1:0] {
    POL_OFF      = 2'b00,
    POL_ON_MATCH = 2'b01,
    POL_ON_MISS  = 2'b10,
    POL_ALWAYS   = 2'b11
  } irq_policy_e;

  // Policy verdict given the masked-compare outcome
  function automatic logic policy_fires(input irq_policy_e pol, input logic cond);
    logic r;
    case (pol)
      POL_OFF:      r = 1'b0;
      POL_ON_MATCH: r = cond;
      POL_ON_MISS:  r = ~cond;
      default:      r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cirq_sel_reg.sv
module cirq_sel_reg #(
  parameter int STAT_W = 16,
  localparam int SEL_W = 2 * STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_data,
  output logic [SEL_W-1:0]  sel_q,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] value_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_data;
  end

  assign mask_o  = sel_q[SEL_W-1:STAT_W];
  assign value_o = sel_q[STAT_W-1:0];

endmodule

// File: rtl/cirq_cond_cmp.sv
module cirq_cond_cmp #(
  parameter int STAT_W = 16
) (
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] value,
  output logic              match
);

  logic [STAT_W-1:0] bit_ok;

  // One lane per status bit: unmasked bits always agree
  for (genvar i = 0; i < STAT_W; i++) begin : g_lane
    assign bit_ok[i] = ~mask[i] | (status[i] ~^ value[i]);
  end

  assign match = &bit_ok;

endmodule

// File: rtl/cirq_decide.sv
module cirq_decide
  import cirq_pkg::*;
#(
  parameter int OPC_W    = 4,
  parameter int STOP_OPC = 7
) (
  input  irq_policy_e      policy,
  input  logic [OPC_W-1:0] opcode,
  input  logic             cond,
  output logic             excluded,
  output logic             allow
);

  localparam logic [OPC_W-1:0] STOP_CODE = OPC_W'(STOP_OPC);

  assign excluded = (opcode >= STOP_CODE);
  assign allow    = ~excluded & policy_fires(policy, cond);

endmodule

// File: rtl/cmpl_irq_eval.sv
module cmpl_irq_eval
  import cirq_pkg::*;
#(
  parameter int STAT_W    = 16,
  parameter int OPC_W     = 4,
  parameter int STOP_OPC  = 7,
  parameter int FIELD_LSB = 4,
  localparam int SEL_W    = 2 * STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr_en,
  input  logic [SEL_W-1:0]  sel_wr_data,
  output logic [SEL_W-1:0]  sel_value,
  input  logic              cmd_done,
  input  logic              run_clear,
  input  logic [7:0]        desc_byte2,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [STAT_W-1:0] chan_status,
  output logic              irq_pulse
);

  // Named internal events for the checker
  logic              eval_stb;
  logic              cond_match;
  logic              opc_excluded;
  logic              fire_ok;
  irq_policy_e       policy;
  logic [STAT_W-1:0] sel_mask;
  logic [STAT_W-1:0] sel_cmp;
  logic [7:0]        byte_unused;

  assign policy      = irq_policy_e'(desc_byte2[FIELD_LSB +: 2]);
  assign byte_unused = desc_byte2;
  assign eval_stb    = cmd_done | run_clear;

  cirq_sel_reg #(.STAT_W(STAT_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sel_wr_en),
    .wr_data (sel_wr_data),
    .sel_q   (sel_value),
    .mask_o  (sel_mask),
    .value_o (sel_cmp)
  );

  cirq_cond_cmp #(.STAT_W(STAT_W)) u_cmp (
    .status (chan_status),
    .mask   (sel_mask),
    .value  (sel_cmp),
    .match  (cond_match)
  );

  cirq_decide #(.OPC_W(OPC_W), .STOP_OPC(STOP_OPC)) u_dec (
    .policy   (policy),
    .opcode   (opcode),
    .cond     (cond_match),
    .excluded (opc_excluded),
    .allow    (fire_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pulse <= 1'b0;
    else        irq_pulse <= eval_stb & fire_ok;
  end

endmodule

// File: rtl/cirq_eval_chk.sv
module cirq_eval_chk
  import cirq_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int OPC_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                eval_stb,
  input logic                cond_match,
  input logic                opc_excluded,
  input irq_policy_e         policy,
  input logic                sel_wr_en,
  input logic [2*STAT_W-1:0] sel_value,
  input logic                irq_pulse
);

  a_r1_no_strobe_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_stb |=> !irq_pulse);

  a_r3_off_policy: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && policy == POL_OFF) |=> !irq_pulse);

  a_r4_always_policy: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && policy == POL_ALWAYS && !opc_excluded) |=> irq_pulse);

  a_r5_match_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && policy == POL_ON_MATCH && cond_match && !opc_excluded) |=> irq_pulse);

  a_r6_miss_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && policy == POL_ON_MISS && !cond_match && !opc_excluded) |=> irq_pulse);

  a_r7_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_stb && opc_excluded) |=> !irq_pulse);

  a_r9_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr_en |=> $stable(sel_value));

endmodule

bind cmpl_irq_eval cirq_eval_chk #(.STAT_W(STAT_W), .OPC_W(OPC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eval_stb     (eval_stb),
  .cond_match   (cond_match),
  .opc_excluded (opc_excluded),
  .policy       (policy),
  .sel_wr_en    (sel_wr_en),
  .sel_value    (sel_value),
  .irq_pulse    (irq_pulse)
);

// File: tb/sim_cmpl_irq_eval.sv
module sim_cmpl_irq_eval;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr_en = 1'b0;
  logic [31:0] sel_wr_data = '0;
  logic [31:0] sel_value;
  logic        cmd_done = 1'b0;
  logic        run_clear = 1'b0;
  logic [7:0]  desc_byte2 = '0;
  logic [3:0]  opcode = '0;
  logic [15:0] chan_status = '0;
  logic        irq_pulse;

  always #5 clk = ~clk;

  cmpl_irq_eval u0 (
    .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
    .sel_value(sel_value), .cmd_done(cmd_done), .run_clear(run_clear),
    .desc_byte2(desc_byte2), .opcode(opcode), .chan_status(chan_status),
    .irq_pulse(irq_pulse)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  // ---------------- reference model ----------------
  bit          exp_irq = 0;
  int unsigned exp_sel = 0;
  string       exp_tag = "R10";

  function automatic bit ref_decide(input int unsigned b, input int unsigned opc,
                                    input int unsigned st, input int unsigned sel,
                                    output string tag);
    int unsigned pol  = (b / 16) % 4;          // R2: bits 5:4 only
    int unsigned msk  = sel / 65536;
    int unsigned cmpv = sel % 65536;
    bit same = (((st ^ cmpv) & msk) == 0);
    if (opc >= 7) begin tag = "R7"; return 0; end
    case (pol)
      0: begin tag = "R3"; return 0; end
      3: begin tag = "R4"; return 1; end
      1: begin tag = "R5"; return same; end
      default: begin tag = "R6"; return !same; end
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_irq <= 0; exp_sel <= 0; exp_tag <= "R10";
    end else begin
      string t;
      bit f;
      f = ref_decide(desc_byte2, opcode, chan_status, exp_sel, t);
      if (cmd_done || run_clear) begin
        exp_irq <= f;
        exp_tag <= run_clear ? {"R8 ", t} : {"R1 ", t};
      end else begin
        exp_irq <= 0;
        exp_tag <= "R1";
      end
      if (sel_wr_en) exp_sel <= sel_wr_data;
    end
  end

  // Compare every cycle, away from the edge
  always @(posedge clk) begin
    #3;
    if (!done_flag) begin
      checks++;
      if (irq_pulse !== exp_irq) begin
        fails++;
        $display("FAIL %s irq_pulse actual=%0b expected=%0b t=%0t", exp_tag, irq_pulse, exp_irq, $time);
      end
      checks++;
      if (sel_value !== exp_sel) begin
        fails++;
        $display("FAIL R9 sel_value actual=%h expected=%h t=%0t", sel_value, exp_sel, $time);
      end
    end
  end

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic drive(input bit d, input bit rc, input logic [7:0] b,
                       input logic [3:0] opc, input logic [15:0] st);
    @(negedge clk);
    sel_wr_en = 0; cmd_done = d; run_clear = rc;
    desc_byte2 = b; opcode = opc; chan_status = st;
  endtask

  task automatic wr_sel(input logic [31:0] v);
    @(negedge clk);
    cmd_done = 0; run_clear = 0; sel_wr_en = 1; sel_wr_data = v;
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_done = 0; run_clear = 0; sel_wr_en = 0;
  endtask

  initial begin
    #200_000_0;
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    // R10: held in reset for a few cycles, compared by the monitor
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    // R9: zero select makes every conditional compare true
    drive(1, 0, 8'h10, 4'd0, 16'hBEEF);  // policy 01 fires
    drive(1, 0, 8'h20, 4'd0, 16'h1234);  // policy 10 silent
    idle();
    // R5/R6 with a real mask: mask 00F0, value 0050
    wr_sel(32'h00F0_0050);
    drive(1, 0, 8'h10, 4'd2, 16'hA55A);  // match -> fire
    drive(1, 0, 8'h10, 4'd2, 16'hA56A);  // miss -> silent
    drive(1, 0, 8'h20, 4'd2, 16'hA56A);  // R6 miss -> fire
    drive(1, 0, 8'h20, 4'd2, 16'h0050);  // R6 match -> silent
    // R2: noise in other bits of the byte
    drive(1, 0, 8'hCF, 4'd1, 16'h0000);  // policy 00 under noise
    drive(1, 0, 8'hDA, 4'd1, 16'h0050);  // policy 01 under noise
    // R3/R4 over opcodes; R7 at and above the stop code
    for (int o = 0; o < 16; o++) begin
      drive(1, 0, 8'h30, o[3:0], 16'h0);
      drive(1, 0, 8'h00, o[3:0], 16'h0);
    end
    // R8: run-bit-clear strobe, and both strobes together
    drive(0, 1, 8'h30, 4'd3, 16'h0);
    drive(1, 1, 8'h30, 4'd3, 16'h0);
    drive(0, 1, 8'h30, 4'd7, 16'h0);
    idle();
    // R9: strobe in the same cycle as a write uses the old value
    @(negedge clk);
    sel_wr_en = 1; sel_wr_data = 32'hFFFF_0000;
    cmd_done = 1; desc_byte2 = 8'h10; opcode = 4'd0; chan_status = 16'h0050;
    drive(1, 0, 8'h10, 4'd0, 16'h0050);  // new value now applies
    idle();
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      sel_wr_en   = ($urandom % 8) == 0;
      sel_wr_data = {16'($urandom), 16'($urandom)};
      cmd_done    = ($urandom % 2) == 1;
      run_clear   = ($urandom % 4) == 0;
      desc_byte2  = 8'($urandom);
      opcode      = 4'($urandom);
      chan_status = ($urandom % 2) ? 16'(sel_value[15:0] ^ ($urandom % 2)) : 16'($urandom);
    end
    idle();
    idle();
    // R10: reset mid-run clears state
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    idle();
    idle();
    report();
  end

endmodule